// File: doc/BRIEF.md
# Multi-Destination RAM Image Copier

This block moves a complete memory image from one RAM to any set of the other RAMs attached to it, so that the processor does not spend its own cycles on the transfer. The processor picks a source RAM and a bit mask of destinations, then pulses a start input. From then on a single down-counting address register drives the address bus shared by every RAM. The engine strobes a read on the source, then writes the returned word into every selected destination in the same cycle. One pass can therefore fill several frame buffers with one background image.

While the copy runs, the engine holds all the RAM buses. The processor-side access port is refused, and the processor sees a low ready flag. The processor can do other work and poll the busy output. At the end, busy drops and a one-cycle done pulse is raised. When the engine is idle, the processor port passes straight through to the selected RAM. Each RAM is assumed to return read data one clock after its read strobe.

Top module: `frame_copy_engine`

## Requirements
- R1: After reset, busy and done are low, no RAM read or write strobe is active, and cpu_ready is high.
- R2: A start pulse seen while idle makes busy high on the next cycle, and the first address driven is all ones.
- R3: Each location takes exactly two cycles on the same address. In the first cycle only the read strobe of the source RAM is high. In the second cycle the write strobes of the selected destinations are high, and the write data equals the source word at that address.
- R4: The address falls by one for each location and ends at zero. Busy stays high for exactly 2·2^ADDR_W cycles. On the cycle after that, busy is low and done is high for exactly one cycle.
- R5: Every RAM whose bit is set in the destination mask (bit i selects RAM i) ends up holding the source image. A RAM whose bit is clear is left unchanged.
- R6: If the destination mask includes the source RAM (src_sel value i selects RAM i), that bit is removed, and the source is never written during the copy.
- R7: A start pulse while busy is ignored. The source, the mask, the address sequence and the length of the copy are not affected by it.
- R8: While busy, cpu_ready is low and processor read or write requests cause no RAM strobe. While idle, a processor write strobes only the selected RAM at cpu_addr, and a processor read returns the selected RAM's word on cpu_rdata one cycle after the request.
- R9: At most one RAM read strobe is high in any cycle, and while a copy runs no cycle carries both read and write strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, sampled on the clock edge |
| src_sel | input | SEL_W | Source RAM index |
| dst_mask | input | NUM_RAMS | Destination mask, bit i selects RAM i |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle pulse when a copy ends |
| cpu_sel | input | SEL_W | RAM chosen for processor access |
| cpu_addr | input | ADDR_W | Processor access address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_re | input | 1 | Processor read request |
| cpu_we | input | 1 | Processor write request |
| cpu_ready | output | 1 | High when processor requests are honoured |
| cpu_rdata | output | DATA_W | Processor read data, one cycle after the request |
| ram_addr | output | ADDR_W | Shared RAM address |
| ram_wdata | output | DATA_W | Shared RAM write data |
| ram_re | output | NUM_RAMS | Per-RAM read strobes |
| ram_we | output | NUM_RAMS | Per-RAM write strobes |
| ram_rdata | input | NUM_RAMS·DATA_W | Read data from all RAMs, RAM i in slice i |

## Verification
The bench builds the engine with ADDR_W=4, DATA_W=8 and NUM_RAMS=4. A whole copy then lasts 32 cycles, so the bench can check every cycle of several complete passes against the expected address, strobe and data pattern. This includes the wrap down to address zero and the done pulse. Four RAMs are enough to cover single-destination copies, broadcast to three RAMs, a mask that includes the source, and untouched bystander RAMs. Start pulses and processor writes are injected in the middle of a copy to show that they change nothing.

// File: rtl/fce_pkg.sv
package fce_pkg;
  typedef enum logic {PH_READ = 1'b0, PH_WRITE = 1'b1} phase_e;
endpackage

// File: rtl/fce_sequencer.sv
module fce_sequencer
  import fce_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_RAMS = 4,
  parameter int SEL_W    = (NUM_RAMS > 1) ? $clog2(NUM_RAMS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SEL_W-1:0]    src_sel,
  input  logic [NUM_RAMS-1:0] dst_mask,
  output logic                busy,
  output logic                done,
  output logic [ADDR_W-1:0]   eng_addr,
  output logic [SEL_W-1:0]    eng_src,
  output logic [NUM_RAMS-1:0] eng_re,
  output logic [NUM_RAMS-1:0] eng_we
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '0;

  phase_e              phase;
  logic [ADDR_W-1:0]   cnt;
  logic [SEL_W-1:0]    src_q;
  logic [NUM_RAMS-1:0] mask_q;
  logic [NUM_RAMS-1:0] src_bit_in;
  logic [NUM_RAMS-1:0] src_bit_q;

  for (genvar g = 0; g < NUM_RAMS; g++) begin : g_dec
    assign src_bit_in[g] = (src_sel == SEL_W'(g));
    assign src_bit_q[g]  = (src_q == SEL_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      phase  <= PH_READ;
      cnt    <= '0;
      src_q  <= '0;
      mask_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          phase  <= PH_READ;
          cnt    <= '1;
          src_q  <= src_sel;
          mask_q <= dst_mask & ~src_bit_in;
        end
      end else if (phase == PH_READ) begin
        phase <= PH_WRITE;
      end else begin
        phase <= PH_READ;
        if (cnt == LAST_ADDR) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign eng_addr = cnt;
  assign eng_src  = src_q;
  assign eng_re   = (busy && phase == PH_READ)  ? src_bit_q : '0;
  assign eng_we   = (busy && phase == PH_WRITE) ? mask_q    : '0;

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && eng_addr == '1 && eng_re != '0)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && $past(eng_addr) == '0)); // R4
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(eng_we) != '0 && eng_re != '0) |-> (eng_addr == $past(eng_addr) - 1'b1)); // R4
  AST_NO_SELF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((eng_we & src_bit_q) == '0)); // R6
  AST_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(eng_src)); // R7
endmodule

// File: rtl/fce_bus_mux.sv
module fce_bus_mux #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int NUM_RAMS = 4,
  parameter int SEL_W    = (NUM_RAMS > 1) ? $clog2(NUM_RAMS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       busy,
  input  logic [ADDR_W-1:0]          eng_addr,
  input  logic [SEL_W-1:0]           eng_src,
  input  logic [NUM_RAMS-1:0]        eng_re,
  input  logic [NUM_RAMS-1:0]        eng_we,
  input  logic [SEL_W-1:0]           cpu_sel,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic [DATA_W-1:0]          cpu_wdata,
  input  logic                       cpu_re,
  input  logic                       cpu_we,
  output logic                       cpu_ready,
  output logic [DATA_W-1:0]          cpu_rdata,
  output logic [ADDR_W-1:0]          ram_addr,
  output logic [DATA_W-1:0]          ram_wdata,
  output logic [NUM_RAMS-1:0]        ram_re,
  output logic [NUM_RAMS-1:0]        ram_we,
  input  logic [NUM_RAMS*DATA_W-1:0] ram_rdata
);
  logic [DATA_W-1:0]   rd_word [NUM_RAMS];
  logic [NUM_RAMS-1:0] cpu_bit;
  logic [SEL_W-1:0]    rd_sel_q;

  for (genvar g = 0; g < NUM_RAMS; g++) begin : g_lane
    assign rd_word[g] = ram_rdata[g*DATA_W +: DATA_W];
    assign cpu_bit[g] = (cpu_sel == SEL_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                rd_sel_q <= '0;
    else if (cpu_re && !busy)  rd_sel_q <= cpu_sel;
  end

  always_comb begin
    if (busy) begin
      ram_addr  = eng_addr;
      ram_wdata = rd_word[eng_src];
      ram_re    = eng_re;
      ram_we    = eng_we;
    end else begin
      ram_addr  = cpu_addr;
      ram_wdata = cpu_wdata;
      ram_re    = cpu_re ? cpu_bit : '0;
      ram_we    = cpu_we ? cpu_bit : '0;
    end
  end

  assign cpu_ready = !busy;
  assign cpu_rdata = rd_word[rd_sel_q];

  AST_CPU_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cpu_we || cpu_re)) |-> (ram_we == eng_we && ram_re == eng_re)); // R8
  AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ram_re)); // R9
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !((|ram_re) && (|ram_we))); // R9
endmodule

// File: rtl/frame_copy_engine.sv
module frame_copy_engine #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int NUM_RAMS = 4,
  parameter int SEL_W    = (NUM_RAMS > 1) ? $clog2(NUM_RAMS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [SEL_W-1:0]           src_sel,
  input  logic [NUM_RAMS-1:0]        dst_mask,
  output logic                       busy,
  output logic                       done,
  input  logic [SEL_W-1:0]           cpu_sel,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic [DATA_W-1:0]          cpu_wdata,
  input  logic                       cpu_re,
  input  logic                       cpu_we,
  output logic                       cpu_ready,
  output logic [DATA_W-1:0]          cpu_rdata,
  output logic [ADDR_W-1:0]          ram_addr,
  output logic [DATA_W-1:0]          ram_wdata,
  output logic [NUM_RAMS-1:0]        ram_re,
  output logic [NUM_RAMS-1:0]        ram_we,
  input  logic [NUM_RAMS*DATA_W-1:0] ram_rdata
);
  logic [ADDR_W-1:0]   eng_addr;
  logic [SEL_W-1:0]    eng_src;
  logic [NUM_RAMS-1:0] eng_re;
  logic [NUM_RAMS-1:0] eng_we;

  fce_sequencer #(.ADDR_W(ADDR_W), .NUM_RAMS(NUM_RAMS), .SEL_W(SEL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .src_sel(src_sel),
    .dst_mask(dst_mask), .busy(busy), .done(done), .eng_addr(eng_addr),
    .eng_src(eng_src), .eng_re(eng_re), .eng_we(eng_we)
  );

  fce_bus_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_RAMS(NUM_RAMS), .SEL_W(SEL_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .busy(busy), .eng_addr(eng_addr),
    .eng_src(eng_src), .eng_re(eng_re), .eng_we(eng_we),
    .cpu_sel(cpu_sel), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_re(cpu_re), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_re(ram_re), .ram_we(ram_we), .ram_rdata(ram_rdata)
  );
endmodule

// File: tb/test_frame_copy_engine.sv
module test_frame_copy_engine;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NR = 4;
  localparam int SW = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [SW-1:0] src_sel = '0;
  logic [NR-1:0] dst_mask = '0;
  logic busy, done, cpu_ready;
  logic [SW-1:0] cpu_sel = '0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_re = 1'b0, cpu_we = 1'b0;
  logic [DW-1:0] cpu_rdata;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [NR-1:0] ram_re, ram_we;
  logic [NR*DW-1:0] ram_rdata;

  logic [DW-1:0] mem  [NR][DEPTH];
  logic [DW-1:0] orig [NR][DEPTH];
  logic [DW-1:0] expm [NR][DEPTH];
  int vectors = 0;
  int fails = 0;

  always #2 clk = ~clk;

  frame_copy_engine #(.ADDR_W(AW), .DATA_W(DW), .NUM_RAMS(NR)) i_frame_copy_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .src_sel(src_sel), .dst_mask(dst_mask),
    .busy(busy), .done(done), .cpu_sel(cpu_sel), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_re(cpu_re), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_re(ram_re), .ram_we(ram_we), .ram_rdata(ram_rdata)
  );

  always @(posedge clk) begin
    for (int i = 0; i < NR; i++) begin
      if (ram_we[i]) mem[i][ram_addr] <= ram_wdata;
      if (ram_re[i]) ram_rdata[i*DW +: DW] <= mem[i][ram_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", {busy, done}, 0);
    chk(ram_re == '0 && ram_we == '0, "R1 strobes", {ram_re, ram_we}, 0);
    chk(cpu_ready == 1'b1, "R1 ready", cpu_ready, 1);
  endtask

  task automatic t_cpu_idle();
    @(negedge clk);
    cpu_sel = 2'd2; cpu_addr = 4'd9; cpu_wdata = 8'h5A; cpu_we = 1'b1;
    #1;
    chk(ram_we == 4'b0100 && ram_addr == 4'd9, "R8 idle write strobe", {ram_we, ram_addr}, {4'b0100, 4'd9});
    @(negedge clk);
    cpu_we = 1'b0; cpu_re = 1'b1;
    @(negedge clk);
    cpu_re = 1'b0;
    chk(cpu_rdata == 8'h5A, "R8 idle readback", cpu_rdata, 8'h5A);
  endtask

  // one full copy, optionally with a start request and a processor write injected mid-copy
  task automatic t_copy(input int src, input logic [NR-1:0] mask, input int seed,
                        input int inj_k, input bit poke);
    logic [NR-1:0] clean;
    int errs_seq;
    clean = mask & ~(NR'(1) << src);
    for (int i = 0; i < NR; i++)
      for (int a = 0; a < DEPTH; a++) begin
        mem[i][a]  = DW'(i * 37 + a * 11 + seed);
        orig[i][a] = mem[i][a];
      end
    for (int i = 0; i < NR; i++)
      for (int a = 0; a < DEPTH; a++)
        expm[i][a] = clean[i] ? orig[src][a] : orig[i][a];
    @(negedge clk);
    start = 1'b1; src_sel = SW'(src); dst_mask = mask;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && ram_addr == '1, "R2 start loads top address", {busy, ram_addr}, {1'b1, 4'hF});
    errs_seq = 0;
    for (int k = 0; k < 2 * DEPTH; k++) begin
      logic [AW-1:0] ea;
      ea = AW'(DEPTH - 1 - k / 2);
      if (busy !== 1'b1 || cpu_ready !== 1'b0 || ram_addr !== ea) begin
        errs_seq++;
        chk(1'b0, "R4 busy/address sequence", {busy, cpu_ready, ram_addr}, {2'b10, ea});
      end
      if ((k % 2) == 0) begin
        if (ram_re !== (NR'(1) << src) || ram_we !== '0) begin
          errs_seq++;
          chk(1'b0, "R3 read phase strobes", {ram_re, ram_we}, {NR'(1) << src, 4'h0});
        end
      end else begin
        if (ram_re !== '0 || ram_we !== clean || ram_wdata !== orig[src][ea]) begin
          errs_seq++;
          chk(1'b0, "R3 write phase strobes/data", {ram_re, ram_we, ram_wdata}, {4'h0, clean, orig[src][ea]});
        end
      end
      start = 1'b0; cpu_we = 1'b0;
      if (k == inj_k) begin
        start = 1'b1; src_sel = SW'(src ^ 1); dst_mask = '1;
        if (poke) begin
          cpu_we = 1'b1; cpu_sel = 2'd3; cpu_addr = 4'd5; cpu_wdata = 8'hAA;
        end
      end
      @(negedge clk);
    end
    start = 1'b0; cpu_we = 1'b0;
    chk(errs_seq == 0, "R3 R4 R7 R9 per-cycle pattern", errs_seq, 0);
    chk(busy == 1'b0 && done == 1'b1, "R4 end: busy low, done high", {busy, done}, 2'b01);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R4 done single cycle", {busy, done}, 0);
    for (int i = 0; i < NR; i++) begin
      int bad;
      bad = 0;
      for (int a = 0; a < DEPTH; a++) if (mem[i][a] !== expm[i][a]) bad++;
      chk(bad == 0, clean[i] ? "R5 destination image" : "R5 R6 R8 untouched RAM", bad, 0);
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    ram_rdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cpu_idle();
    t_copy(0, 4'b0010, 3, -1, 1'b0);   // single destination
    t_copy(2, 4'b1011, 17, -1, 1'b0);  // broadcast to three
    t_copy(1, 4'b0110, 41, -1, 1'b0);  // R6: source in mask dropped
    t_copy(3, 4'b0101, 59, 5, 1'b0);   // R7: start while busy
    t_copy(0, 4'b0010, 77, 8, 1'b1);   // R8: processor write to RAM 3 while busy
    t_cpu_idle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule